// File: doc/BRIEF.md
# Gated Pulse Accumulator

This block is an 8-bit accumulator that either counts transitions on an external input or measures how long that input stays at an active level. In event mode each qualified transition adds one to the count. In gated mode the count advances on a divided internal tick, but only while the synchronized input sits at its active level. Software accesses it as a 16-bit word. The upper byte holds the control fields, the overflow flag and a live pin-state bit. The lower byte holds the count.

Each byte of the word has its own write enable. A write to the count byte overrides any increment in the same cycle. The count wraps from 0xFF to 0x00, and each wrap sets a sticky overflow flag. Software clears that flag by writing a 1 to it. The input passes through a two-flop synchronizer before any edge or level test.

Top module: `pulse_accum`

## Requirements
- R1: After synchronous reset, bits 14:8 of `rd_data` read 0, the count reads 0x00 and `ovf_flag` is 0.
- R2: Word layout:
  - bit 14 is enable, bit 13 is mode (0 event, 1 gated) and bit 12 is polarity. Each reads back what was last written.
  - bits 9:8 are the tick select. They read back what was last written.
  - bit 11 reads the overflow flag and bit 10 reads 0.
  - bits 7:0 hold the count.
  - `wr_be[1]` writes bits 15:8 only and `wr_be[0]` writes bits 7:0 only. Each leaves the other byte unchanged.
- R3: Bit 15 of `rd_data` shows the input pin after two clock edges of synchronization. It is still old after one edge.
- R4: With enable at 0, the count does not change in either mode, however the pin toggles.
- R5: In event mode, polarity 0 adds one per falling edge and polarity 1 adds one per rising edge. The new count is readable after the third clock edge following the pin change.
- R6: In gated mode, the count advances once per tick while the synchronized pin is at its active level: high for polarity 0, low for polarity 1. It does not advance while the pin is inactive.
- R7: The gated tick period is 64 << select cycles (64, 128, 256 or 512). The tick divider is held cleared unless enable=1 and mode=1. The first tick therefore lands exactly one period after the edge that enables gated mode.
- R8: An increment from 0xFF yields 0x00 and sets the sticky overflow flag. `ovf_flag` and bit 11 stay 1 through later counting.
- R9: A high-byte write with bit 11 = 1 clears the flag, and bit 11 = 0 leaves it alone. If a wrap happens in the same cycle as a clear, the flag ends set.
- R10: A low-byte write that coincides with an increment loads the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous accumulator input |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables: [1] control byte, [0] count byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Control/count word readback |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest case is a software write that lands on the exact edge where a gated tick increments the count. A write-to-clear that meets a wrap on that same edge is just as hard. The tick divider restarts from zero when gated mode is switched on, so the bench knows the exact edge of every tick. It times the write strobe for the edge one full period after the enabling write. All four tick selects and both polarities are swept with exact arithmetic expectations.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int CNT_W = 8;
    localparam int SEL_W = 2;

    // Word bit positions: software decodes these
    localparam int B_PIN  = 15;
    localparam int B_EN   = 14;
    localparam int B_MODE = 13;
    localparam int B_POL  = 12;
    localparam int B_OVF  = 11;
    localparam int B_SEL  = 8;

    typedef enum logic {
        MODE_EVENT = 1'b0,
        MODE_GATED = 1'b1
    } pacc_mode_e;

    typedef struct packed {
        logic             en;
        pacc_mode_e       mode;
        logic             pol;
        logic [SEL_W-1:0] sel;
    } pacc_ctrl_t;

    function automatic pacc_ctrl_t unpack_ctrl(logic [15:0] w);
        pacc_ctrl_t c;
        c.en   = w[B_EN];
        c.mode = pacc_mode_e'(w[B_MODE]);
        c.pol  = w[B_POL];
        c.sel  = w[B_SEL +: SEL_W];
        return c;
    endfunction

    function automatic logic [15:0] pack_word(logic pin, pacc_ctrl_t c,
                                              logic ovf, logic [CNT_W-1:0] cnt);
        logic [15:0] w;
        w = '0;
        w[B_PIN]  = pin;
        w[B_EN]   = c.en;
        w[B_MODE] = c.mode;
        w[B_POL]  = c.pol;
        w[B_OVF]  = ovf;
        w[B_SEL +: SEL_W] = c.sel;
        w[CNT_W-1:0] = cnt;
        return w;
    endfunction

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    // STAGES flops of synchronization plus one history flop for edges
    logic [STAGES:0] chain;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b0;
                else if (i == 0)
                    chain[i] <= pin;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign lvl  = chain[STAGES-1];
    assign rise =  chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int BASE_LOG2 = 6,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PW = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [PW-1:0] pc;
    logic [PW-1:0] mask;

    always_comb begin
        for (int i = 0; i < PW; i++)
            mask[i] = (i < BASE_LOG2 + int'(sel));
    end

    // tick when every bit inside the selected window is 1
    assign tick = run & (&(pc | ~mask));

    always_ff @(posedge clk) begin
        if (rst || !run)
            pc <= '0;
        else
            pc <= pc + 1'b1;
    end
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic wrap;

    assign wrap = inc & ~load & (&cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (load)
                cnt <= load_val;
            else if (inc)
                cnt <= cnt + 1'b1;

            if (wrap)
                ovf <= 1'b1;
            else if (ovf_clr)
                ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int PRE_BASE_LOG2 = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_in,
    input  logic        wr_en,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        ovf_flag
);
    pacc_ctrl_t       ctrl;
    logic             wr_hi, wr_lo;
    logic             lvl, rise, fall;
    logic             tick, run, inc, active;
    logic [CNT_W-1:0] cnt;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[B_PIN], wr_data[10]};

    assign wr_hi = wr_en & wr_be[1];
    assign wr_lo = wr_en & wr_be[0];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_hi)
            ctrl <= unpack_ctrl(wr_data);
    end

    pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (pin_in),
        .lvl (lvl),
        .rise(rise),
        .fall(fall)
    );

    assign run = ctrl.en & (ctrl.mode == MODE_GATED);

    pacc_prescale #(.BASE_LOG2(PRE_BASE_LOG2), .SEL_W(SEL_W)) u_pre (
        .clk (clk),
        .rst (rst),
        .run (run),
        .sel (ctrl.sel),
        .tick(tick)
    );

    assign active = lvl ^ ctrl.pol;

    always_comb begin
        if (!ctrl.en)
            inc = 1'b0;
        else if (ctrl.mode == MODE_GATED)
            inc = tick & active;
        else
            inc = ctrl.pol ? rise : fall;
    end

    pacc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .load    (wr_lo),
        .load_val(wr_data[CNT_W-1:0]),
        .ovf_clr (wr_hi & wr_data[B_OVF]),
        .cnt     (cnt),
        .ovf     (ovf_flag)
    );

    assign rd_data = pack_word(lvl, ctrl, ovf_flag, cnt);
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [7:0]  wr_cnt,
    input logic        wr_clr,
    input logic [15:0] rd_data,
    input logic        ovf_flag
);
    logic lo_wr, hi_clr;
    assign lo_wr  = wr_en & wr_be[0];
    assign hi_clr = wr_en & wr_be[1] & wr_clr;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> rd_data[7:0] == $past(wr_cnt)); // R10

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[14] && !lo_wr) |=> $stable(rd_data[7:0])); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !lo_wr |=> (rd_data[7:0] == $past(rd_data[7:0]) ||
                    rd_data[7:0] == 8'($past(rd_data[7:0]) + 8'd1))); // R5

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (rst)
        (!lo_wr && rd_data[7:0] == 8'hFF) |=>
            (rd_data[7:0] == 8'hFF || (rd_data[7:0] == 8'h00 && ovf_flag))); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !hi_clr) |=> ovf_flag); // R9
endmodule

bind pulse_accum pacc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_cnt  (wr_data[7:0]),
    .wr_clr  (wr_data[11]),
    .rd_data (rd_data),
    .ovf_flag(ovf_flag)
);

// File: tb/pulse_accum_test.sv
`timescale 1ns/1ps
module pulse_accum_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pulse_accum uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en),
        .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .ovf_flag(ovf_flag)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    // control byte: en bit14, mode bit13, pol bit12, sel bits 9:8
    function automatic logic [15:0] ctl(bit en, bit md, bit pol, int sel);
        return {1'b0, en, md, pol, 2'b00, 2'(sel), 8'h00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        check("R1 word", {1'b0, rd_data[14:0]}, 16'h0000);
        check("R1 ovf", 16'(ovf_flag), 16'h0);

        // R2 control sweep (pin low, count 0: no counting reachable)
        for (int v = 0; v < 128; v++) begin
            wr(2'b10, {1'b0, 7'(v), 8'h00});
            check("R2 ctrl readback", 16'(rd_data[14:8]), 16'(7'(v) & 7'h73));
        end
        wr(2'b10, 16'h0000);
        wr(2'b01, 16'hFFA5);
        check("R2 low byte only", rd_data[14:0], 15'h00A5);
        wr(2'b10, ctl(0, 1, 1, 2) | 16'h00FF);
        check("R2 high byte only", rd_data[14:0], 15'h32A5);
        wr(2'b10, 16'h0000);

        // R3 synchronizer latency
        pin_in = 1'b1;
        cyc(1);
        check("R3 one edge", 16'(rd_data[15]), 16'h0);
        cyc(1);
        check("R3 two edges", 16'(rd_data[15]), 16'h1);
        pin_in = 1'b0;
        cyc(4);

        // R4 disabled in both modes
        for (int md = 0; md < 2; md++) begin
            wr(2'b01, 16'h0033);
            wr(2'b10, ctl(0, 1'(md), 0, 0));
            for (int k = 0; k < 6; k++) begin
                pin_in = ~pin_in;
                cyc(70);
            end
            check("R4 no count when disabled", 16'(rd_data[7:0]), 16'h0033);
        end
        pin_in = 1'b0;
        wr(2'b10, 16'h0000);
        cyc(4);

        // R5 event counting, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            wr(2'b01, 16'h0000);
            wr(2'b10, ctl(1, 0, 1'(pol), 0));
            for (int k = 0; k < 5; k++) begin
                pin_in = 1'b1;
                cyc(2);
                check("R5 before third edge", 16'(rd_data[7:0]), 16'(k));
                cyc(1);
                check("R5 after rise", 16'(rd_data[7:0]), 16'(pol ? k + 1 : k));
                pin_in = 1'b0;
                cyc(4);
                check("R5 after fall", 16'(rd_data[7:0]), 16'(k + 1));
            end
            wr(2'b10, 16'h0000);
        end

        // R6/R7 gated accumulation over all selects and polarities
        for (int sel = 0; sel < 4; sel++) begin
            for (int pol = 0; pol < 2; pol++) begin
                int div;
                div = 64 << sel;
                wr(2'b10, 16'h0000);
                pin_in = pol ? 1'b0 : 1'b1;
                cyc(4);
                wr(2'b01, 16'h0000);
                wr(2'b10, ctl(1, 1, 1'(pol), sel));
                cyc(div - 1);
                check("R7 before first tick", 16'(rd_data[7:0]), 16'h0);
                cyc(1);
                check("R7 first tick", 16'(rd_data[7:0]), 16'h1);
                cyc(2 * div);
                check("R6 active ticks", 16'(rd_data[7:0]), 16'h3);
                pin_in = ~pin_in;
                cyc(3 * div);
                check("R6 inactive hold", 16'(rd_data[7:0]), 16'h3);
                pin_in = ~pin_in;
                cyc(div);
                check("R6 resume", 16'(rd_data[7:0]), 16'h4);
            end
        end
        wr(2'b10, 16'h0000);
        pin_in = 1'b0;
        cyc(4);

        // R8/R9 wrap and sticky flag (event mode, rising edges)
        wr(2'b01, 16'h00FE);
        wr(2'b10, ctl(1, 0, 1, 0));
        pin_in = 1'b1; cyc(4); pin_in = 1'b0; cyc(4);
        check("R8 at FF no flag", {rd_data[11], rd_data[7:0]}, 9'h0FF);
        pin_in = 1'b1; cyc(4); pin_in = 1'b0; cyc(4);
        check("R8 wrap to 00", 16'(rd_data[7:0]), 16'h0);
        check("R8 flag set", 16'({ovf_flag, rd_data[11]}), 16'h3);
        pin_in = 1'b1; cyc(4); pin_in = 1'b0; cyc(4);
        check("R8 flag sticky", 16'({ovf_flag, rd_data[7:0]}), 16'h101);
        wr(2'b10, ctl(1, 0, 1, 0));
        check("R9 write 0 keeps", 16'(ovf_flag), 16'h1);
        wr(2'b10, ctl(1, 0, 1, 0) | 16'h0800);
        check("R9 write 1 clears", 16'({ovf_flag, rd_data[11]}), 16'h0);

        // R9 wrap meets clear on the same edge (gated, sel 0, pin high)
        wr(2'b10, 16'h0000);
        pin_in = 1'b1;
        cyc(4);
        wr(2'b01, 16'h00FF);
        wr(2'b10, ctl(1, 1, 0, 0));
        cyc(63);
        wr(2'b10, ctl(1, 1, 0, 0) | 16'h0800);
        check("R9 set beats clear", 16'({ovf_flag, rd_data[7:0]}), 16'h100);

        // R10 load beats increment on the same edge
        wr(2'b10, 16'h0800);
        wr(2'b01, 16'h0010);
        wr(2'b10, ctl(1, 1, 0, 0));
        cyc(63);
        wr(2'b01, 16'h0055);
        check("R10 load wins", 16'(rd_data[7:0]), 16'h0055);
        cyc(64);
        check("R10 count continues", 16'(rd_data[7:0]), 16'h0056);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule